// File: doc/BRIEF.md
# Protection Fault Latch and Reporter

This block gathers the protection events of a four-channel high-side output stage. It decides how long each event stays recorded, and it publishes the result in three ways. The first is a latched fault register that the SPI shifter sends out. The second is an active-low fault pin. The third is a set of per-channel inhibit flags that force the matching output off.

Each fault class has its own clearing rule. Over-current, severe short-circuit and over-temperature stay latched on their channel until that channel receives a new turn-on command, which is a rising edge of its control line. Under-voltage is a single global bit. It is latched until any channel receives a turn-on edge, and it is already set when the block leaves reset. Off-state faults (output shorted to supply, open load) and over-voltage follow their detector directly. Open load while the output is on is written only into the register.

The report register keeps an event after its condition has ended. The first valid SPI transfer strobe clears the report bits whose condition is no longer present. A clear pulse from the mode controller wipes every latch and every report bit. When an event and a clear fall in the same cycle, the event wins.

Top module: `fault_latch_rpt`

## Requirements
- R1: When reset is released, `fault_reg_o` holds only bit 25 (under-voltage), `fault_no_o` is 0, every `inhibit_o` bit is 1 and over-voltage detection is enabled.
- R2: Report field layout: channel c owns bits 6c+0 (over-temperature), 6c+1 (over-current), 6c+2 (severe short), 6c+3 (short to supply while off), 6c+4 (open load while off) and 6c+5 (open load while on). Bit 24 is over-voltage and bit 25 is under-voltage. An over-temperature, over-current or severe-short detect latches that channel's bit and sets `inhibit_o[c]` one cycle later. Both stay set after the detect drops and are released only by a 0-to-1 edge of `turn_on_ctl_i[c]`.
- R3: A short-to-supply or open-load-off detect pulls `fault_no_o` low one cycle later. The pin returns high one cycle after the detect drops, provided no other pin fault is present. These detects never set `inhibit_o`.
- R4: Open load while on sets its register bit but never pulls `fault_no_o` low and never sets `inhibit_o`.
- R5: Over-voltage sets bit 24 and pulls `fault_no_o` low while detection is enabled. A cycle with `ov_cfg_we_i`=1 loads `ov_cfg_i` as the enable. While the enable is 0, over-voltage detects have no effect.
- R6: An under-voltage detect sets bit 25 and all `inhibit_o` bits. The latch is released by a turn-on edge on any channel.
- R7: A report bit stays set after its condition ends. `spi_first_i` clears it on the next edge, unless the condition is still present or still latched.
- R8: `clear_i` releases all latches and clears all report bits on the next edge.
- R9: A detect that is active in the same cycle as `clear_i`, `spi_first_i` or a turn-on edge still sets its latch and its report bit.
- R10: `fault_no_o` is low exactly when a latched or live fault other than open load while on is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| det_ot_i | input | 4 | Over-temperature detect per channel |
| det_oc_i | input | 4 | Over-current detect per channel |
| det_ssc_i | input | 4 | Severe short-circuit detect per channel |
| det_sts_i | input | 4 | Output shorted to supply while off, per channel |
| det_olf_i | input | 4 | Open load while off, per channel |
| det_oln_i | input | 4 | Open load while on, per channel |
| det_ov_i | input | 1 | Supply over-voltage detect |
| det_uv_i | input | 1 | Supply under-voltage detect |
| ov_cfg_we_i | input | 1 | Load strobe for the over-voltage enable |
| ov_cfg_i | input | 1 | Over-voltage enable value |
| turn_on_ctl_i | input | 4 | Per-channel turn-on control lines |
| spi_first_i | input | 1 | First valid SPI transfer strobe (read clear) |
| clear_i | input | 1 | Global clear from a mode transition |
| fault_reg_o | output | 26 | Latched fault report register |
| fault_no_o | output | 1 | Fault pin, active low |
| inhibit_o | output | 4 | Per-channel output inhibit |

## Verification
The bench builds the block with its default of four channels. This puts the highest per-channel field (bit 23), the two global bits and simultaneous events on every channel within reach. The walked vectors step through each class's release rule in turn: turn-on edge, condition removal, read strobe and global clear. The directed tests cover the over-voltage enable, reset returning the enable to its default, and the set-over-clear races.

// File: rtl/fault_pkg.sv
package fault_pkg;
  localparam int unsigned CH_KINDS = 6;
  localparam int unsigned K_OT  = 0;
  localparam int unsigned K_OC  = 1;
  localparam int unsigned K_SSC = 2;
  localparam int unsigned K_STS = 3;
  localparam int unsigned K_OLF = 4;
  localparam int unsigned K_OLN = 5;
  localparam int unsigned GLOBAL_BITS = 2;

  // bit order matches the report field layout: ot is bit 0
  typedef struct packed {
    logic oln;
    logic olf;
    logic sts;
    logic ssc;
    logic oc;
    logic ot;
  } ch_flt_t;
endpackage

// File: rtl/fault_chan_latch.sv
module fault_chan_latch
  import fault_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    det_ot_i,
  input  logic    det_oc_i,
  input  logic    det_ssc_i,
  input  logic    det_sts_i,
  input  logic    det_olf_i,
  input  logic    det_oln_i,
  input  logic    turn_on_i,
  input  logic    clear_i,
  output ch_flt_t cond_o,
  output ch_flt_t cond_nxt_o,
  output logic    inhibit_o
);
  ch_flt_t q, d;
  logic    rel;

  assign rel = turn_on_i | clear_i;

  always_comb begin
    // turn-on class: set wins over release
    d.ot  = det_ot_i  | (q.ot  & ~rel);
    d.oc  = det_oc_i  | (q.oc  & ~rel);
    d.ssc = det_ssc_i | (q.ssc & ~rel);
    // live class
    d.sts = det_sts_i;
    d.olf = det_olf_i;
    d.oln = det_oln_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign cond_o     = q;
  assign cond_nxt_o = d;
  assign inhibit_o  = q.ot | q.oc | q.ssc;
endmodule

// File: rtl/fault_global_latch.sv
module fault_global_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic det_ov_i,
  input  logic det_uv_i,
  input  logic ov_cfg_we_i,
  input  logic ov_cfg_i,
  input  logic any_turn_on_i,
  input  logic clear_i,
  output logic ov_o,
  output logic uv_o,
  output logic ov_nxt_o,
  output logic uv_nxt_o
);
  logic ov_en_q, ov_q, uv_q;
  logic ov_d, uv_d;

  assign ov_d = det_ov_i & ov_en_q;
  assign uv_d = det_uv_i | (uv_q & ~(any_turn_on_i | clear_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ov_en_q <= 1'b1;
      ov_q    <= 1'b0;
      uv_q    <= 1'b1;   // supply assumed low at power-up
    end else begin
      if (ov_cfg_we_i) ov_en_q <= ov_cfg_i;
      ov_q <= ov_d;
      uv_q <= uv_d;
    end
  end

  assign ov_o     = ov_q;
  assign uv_o     = uv_q;
  assign ov_nxt_o = ov_d;
  assign uv_nxt_o = uv_d;
endmodule

// File: rtl/fault_report_reg.sv
module fault_report_reg #(
  parameter int unsigned          W       = 26,
  parameter logic [W-1:0]         RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cond_nxt_i,
  input  logic         rd_clr_i,
  input  logic         clear_i,
  output logic [W-1:0] rep_o
);
  logic [W-1:0] q;
  logic         wipe;

  assign wipe = rd_clr_i | clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= RST_VAL;
    else         q <= cond_nxt_i | (q & ~{W{wipe}});
  end

  assign rep_o = q;
endmodule

// File: rtl/fault_latch_rpt.sv
module fault_latch_rpt
  import fault_pkg::*;
#(
  parameter int unsigned NCH = 4,
  localparam int unsigned REG_W = NCH * CH_KINDS + GLOBAL_BITS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   det_ot_i,
  input  logic [NCH-1:0]   det_oc_i,
  input  logic [NCH-1:0]   det_ssc_i,
  input  logic [NCH-1:0]   det_sts_i,
  input  logic [NCH-1:0]   det_olf_i,
  input  logic [NCH-1:0]   det_oln_i,
  input  logic             det_ov_i,
  input  logic             det_uv_i,
  input  logic             ov_cfg_we_i,
  input  logic             ov_cfg_i,
  input  logic [NCH-1:0]   turn_on_ctl_i,
  input  logic             spi_first_i,
  input  logic             clear_i,
  output logic [REG_W-1:0] fault_reg_o,
  output logic             fault_no_o,
  output logic [NCH-1:0]   inhibit_o
);
  localparam int unsigned OV_BIT = NCH * CH_KINDS;
  localparam int unsigned UV_BIT = OV_BIT + 1;
  localparam logic [REG_W-1:0] REP_RST = REG_W'(1) << UV_BIT;

  logic [NCH-1:0]   ctl_q, turn_on, ch_inh;
  logic [NCH-1:0]   ch_pin;
  logic [REG_W-1:0] cond_nxt;
  logic             ov_q, uv_q, ov_d, uv_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else         ctl_q <= turn_on_ctl_i;
  end

  assign turn_on = turn_on_ctl_i & ~ctl_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ch_flt_t cq, cd;
    fault_chan_latch u_lat (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .det_ot_i   (det_ot_i[c]),
      .det_oc_i   (det_oc_i[c]),
      .det_ssc_i  (det_ssc_i[c]),
      .det_sts_i  (det_sts_i[c]),
      .det_olf_i  (det_olf_i[c]),
      .det_oln_i  (det_oln_i[c]),
      .turn_on_i  (turn_on[c]),
      .clear_i    (clear_i),
      .cond_o     (cq),
      .cond_nxt_o (cd),
      .inhibit_o  (ch_inh[c])
    );
    assign cond_nxt[c*CH_KINDS +: CH_KINDS] = cd;
    // open load while on never reaches the pin
    assign ch_pin[c] = cq.ot | cq.oc | cq.ssc | cq.sts | cq.olf;
  end

  fault_global_latch u_glb (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .det_ov_i      (det_ov_i),
    .det_uv_i      (det_uv_i),
    .ov_cfg_we_i   (ov_cfg_we_i),
    .ov_cfg_i      (ov_cfg_i),
    .any_turn_on_i (|turn_on),
    .clear_i       (clear_i),
    .ov_o          (ov_q),
    .uv_o          (uv_q),
    .ov_nxt_o      (ov_d),
    .uv_nxt_o      (uv_d)
  );

  assign cond_nxt[OV_BIT] = ov_d;
  assign cond_nxt[UV_BIT] = uv_d;

  fault_report_reg #(.W(REG_W), .RST_VAL(REP_RST)) u_rep (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cond_nxt_i (cond_nxt),
    .rd_clr_i   (spi_first_i),
    .clear_i    (clear_i),
    .rep_o      (fault_reg_o)
  );

  assign fault_no_o = ~(|ch_pin | ov_q | uv_q);
  assign inhibit_o  = ch_inh | {NCH{uv_q}};
endmodule

// File: rtl/fault_latch_rpt_chk.sv
module fault_latch_rpt_chk
  import fault_pkg::*;
#(
  parameter int unsigned NCH = 4,
  localparam int unsigned REG_W = NCH * CH_KINDS + GLOBAL_BITS
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NCH-1:0]   det_ot_i,
  input logic [NCH-1:0]   det_oc_i,
  input logic [NCH-1:0]   det_ssc_i,
  input logic [NCH-1:0]   det_sts_i,
  input logic [NCH-1:0]   det_olf_i,
  input logic [NCH-1:0]   det_oln_i,
  input logic             det_ov_i,
  input logic             det_uv_i,
  input logic             clear_i,
  input logic [REG_W-1:0] fault_reg_o,
  input logic             fault_no_o,
  input logic [NCH-1:0]   inhibit_o
);
  logic [NCH-1:0] latch_det, oln_pos, sts_pos;
  logic           no_det;

  assign latch_det = det_ot_i | det_oc_i | det_ssc_i;
  assign no_det = ~(|(latch_det | det_sts_i | det_olf_i | det_oln_i)) & ~det_ov_i & ~det_uv_i;

  for (genvar c = 0; c < NCH; c++) begin : g_pos
    assign oln_pos[c] = fault_reg_o[c*CH_KINDS + K_OLN];
    assign sts_pos[c] = fault_reg_o[c*CH_KINDS + K_STS];
  end

  AST_LATCH_PIN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|latch_det) |=> !fault_no_o); // R2

  AST_LATCH_INHIBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((inhibit_o & $past(latch_det)) == $past(latch_det))); // R2

  AST_UV_ALL_INHIBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_uv_i |=> (&inhibit_o && fault_reg_o[REG_W-1])); // R6

  AST_CLEAR_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && no_det) |=> (fault_reg_o == '0)); // R8

  AST_OLN_RECORDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((oln_pos & $past(det_oln_i)) == $past(det_oln_i))); // R4

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sts_pos & $past(det_sts_i)) == $past(det_sts_i))); // R9
endmodule

bind fault_latch_rpt fault_latch_rpt_chk #(.NCH(NCH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .det_ot_i    (det_ot_i),
  .det_oc_i    (det_oc_i),
  .det_ssc_i   (det_ssc_i),
  .det_sts_i   (det_sts_i),
  .det_olf_i   (det_olf_i),
  .det_oln_i   (det_oln_i),
  .det_ov_i    (det_ov_i),
  .det_uv_i    (det_uv_i),
  .clear_i     (clear_i),
  .fault_reg_o (fault_reg_o),
  .fault_no_o  (fault_no_o),
  .inhibit_o   (inhibit_o)
);

// File: tb/fault_latch_rpt_test.sv
module fault_latch_rpt_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int REG_W = 26;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [NCH-1:0] det_ot_i = '0, det_oc_i = '0, det_ssc_i = '0;
  logic [NCH-1:0] det_sts_i = '0, det_olf_i = '0, det_oln_i = '0;
  logic det_ov_i = 1'b0, det_uv_i = 1'b0;
  logic ov_cfg_we_i = 1'b0, ov_cfg_i = 1'b0;
  logic [NCH-1:0] turn_on_ctl_i = '0;
  logic spi_first_i = 1'b0, clear_i = 1'b0;
  logic [REG_W-1:0] fault_reg_o;
  logic fault_no_o;
  logic [NCH-1:0] inhibit_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fault_latch_rpt #(.NCH(NCH)) uut (.*);

  typedef struct packed {
    logic [3:0] ot, oc, ssc, sts, olf, oln;
    logic ov, uv;
    logic [3:0] ctl;
    logic rd, clr;
    logic [25:0] rep;
    logic pin;
    logic [3:0] inh;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,4'h1,1'b0,1'b0,26'h2000000,1'b1,4'h0,4'd6}, // R6 uv released
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,4'h1,1'b1,1'b0,26'h0000000,1'b1,4'h0,4'd7}, // R7
    '{4'h0,4'h2,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,4'h1,1'b0,1'b0,26'h0000080,1'b0,4'h2,4'd2}, // R2
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,4'h1,1'b0,1'b0,26'h0000080,1'b0,4'h2,4'd2}, // R2 held
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,4'h1,1'b1,1'b0,26'h0000080,1'b0,4'h2,4'd7}, // R7 latched survives read
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,4'h3,1'b0,1'b0,26'h0000080,1'b1,4'h0,4'd2}, // R2 turn-on release
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,4'h3,1'b1,1'b0,26'h0000000,1'b1,4'h0,4'd7}, // R7
    '{4'h0,4'h0,4'h0,4'h4,4'h0,4'h0,1'b0,1'b0,4'h3,1'b0,1'b0,26'h0008000,1'b0,4'h0,4'd3}, // R3
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,4'h3,1'b0,1'b0,26'h0008000,1'b1,4'h0,4'd3}, // R3 pin returns
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h8,1'b0,1'b0,4'h3,1'b0,1'b0,26'h0808000,1'b1,4'h0,4'd4}, // R4
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,4'h3,1'b1,1'b0,26'h0000000,1'b1,4'h0,4'd4}, // R4
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b1,1'b0,4'h3,1'b0,1'b0,26'h1000000,1'b0,4'h0,4'd5}, // R5
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,4'h3,1'b1,1'b0,26'h0000000,1'b1,4'h0,4'd5}, // R5
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b1,4'h3,1'b0,1'b0,26'h2000000,1'b0,4'hF,4'd6}, // R6
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,4'h7,1'b0,1'b0,26'h2000000,1'b1,4'h0,4'd6}, // R6 any edge
    '{4'h1,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,4'h7,1'b0,1'b1,26'h0000001,1'b0,4'h1,4'd9}, // R9 set vs clear
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,4'h7,1'b0,1'b1,26'h0000000,1'b1,4'h0,4'd8}, // R8
    '{4'h0,4'h0,4'h1,4'h0,4'h0,4'h0,1'b0,1'b0,4'h6,1'b0,1'b0,26'h0000004,1'b0,4'h1,4'd2}, // R2
    '{4'h0,4'h0,4'h1,4'h0,4'h0,4'h0,1'b0,1'b0,4'h7,1'b0,1'b0,26'h0000004,1'b0,4'h1,4'd9}, // R9 set vs turn-on
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,4'h7,1'b1,1'b0,26'h0000004,1'b0,4'h1,4'd7}, // R7
    '{4'h0,4'h0,4'h0,4'h0,4'h2,4'h0,1'b0,1'b0,4'h7,1'b0,1'b1,26'h0000400,1'b0,4'h0,4'd8}, // R8 with live olf
    '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,4'h7,1'b0,1'b1,26'h0000000,1'b1,4'h0,4'd8}  // R8
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk_out(input string req, input logic [25:0] rep, input logic pin, input logic [3:0] inh);
    chk(fault_reg_o == rep, {req, " reg"}, 32'(fault_reg_o), 32'(rep));
    chk(fault_no_o == pin, {req, " pin"}, 32'(fault_no_o), 32'(pin));
    chk(inhibit_o == inh, {req, " inhibit"}, 32'(inhibit_o), 32'(inh));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_out("R1", 26'h2000000, 1'b0, 4'hF);

    for (int i = 0; i < NV; i++) begin
      det_ot_i = VEC[i].ot;   det_oc_i = VEC[i].oc;   det_ssc_i = VEC[i].ssc;
      det_sts_i = VEC[i].sts; det_olf_i = VEC[i].olf; det_oln_i = VEC[i].oln;
      det_ov_i = VEC[i].ov;   det_uv_i = VEC[i].uv;
      turn_on_ctl_i = VEC[i].ctl;
      spi_first_i = VEC[i].rd; clear_i = VEC[i].clr;
      step();
      chk_out($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].rep, VEC[i].pin, VEC[i].inh);
    end
    spi_first_i = 1'b0; clear_i = 1'b0;

    // R5: disable over-voltage, then detect is ignored
    ov_cfg_we_i = 1'b1; ov_cfg_i = 1'b0;
    step();
    ov_cfg_we_i = 1'b0; det_ov_i = 1'b1;
    step();
    chk_out("R5 disabled", 26'h0, 1'b1, 4'h0);
    det_ov_i = 1'b0;

    // R10 / R2: all channels over-current together
    det_oc_i = 4'hF;
    step();
    chk_out("R10 all oc", 26'h0082082, 1'b0, 4'hF);
    det_oc_i = 4'h0; clear_i = 1'b1;
    step();
    chk_out("R10 cleared", 26'h0, 1'b1, 4'h0);
    clear_i = 1'b0;

    // R1 / R5: reset restores defaults including over-voltage enable
    turn_on_ctl_i = 4'h0;
    rst_ni = 1'b0;
    step();
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_out("R1 re-reset", 26'h2000000, 1'b0, 4'hF);
    turn_on_ctl_i = 4'h1;
    step();
    det_ov_i = 1'b1;
    step();
    chk_out("R5 default on", 26'h3000000, 1'b0, 4'h0);
    det_ov_i = 1'b0;
    step();
    chk(fault_no_o == 1'b1, "R10 pin idle", 32'(fault_no_o), 32'd1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule